// File: doc/BRIEF.md
# Cluster Low-Power Sequencer and Clock-Enable Controller

This block sits between a processor cluster and the system controller that owns its power. It does two jobs. First, it walks the cluster towards a state where power can safely be removed. The core starts the walk by requesting a cache flush. The block then waits for the flush to finish and for the core to halt in wait-for-interrupt. It then waits for the coherency handshake to drop. At that point it raises a power-off request to the system. Second, it computes the enable for the cluster's clock-gate cell. The clock is stopped while the core idles in wait-for-interrupt and the sequencer is idle. The clock is also stopped while a soft reset ends a power-down.

The soft reset input reaches the internal state through a short synchronizer. The main reset acts on every register at once, without waiting for a clock edge. An incoming snoop raises the clock enable in the same cycle, without passing through any register. An interrupt wakes the gated clock one register stage later.

Top module: `cpu_lp_ctrl`

## Requirements
- R1: After the main reset is released and the soft reset has been synchronized, `clk_en` is 1 and `pwr_off_req` is 0.
- R2: The sequencer always steps through its states in one fixed order: idle, then flush, then wait-for-WFI, then coherency exit, then power-off. It leaves idle on `flush_req`. It leaves flush on `flush_done`. It leaves wait-for-WFI on `core_wfi`. `pwr_off_req` is 1 exactly while the sequencer is in the power-off state, and it rises one cycle after the exit condition is seen.
- R3: The sequencer leaves the coherency-exit state only in a cycle where `coh_req` and `coh_ack` are both 0. While either of them is 1, it waits.
- R4: Once in the power-off state, the sequencer stays there until a reset. `flush_req`, `core_wfi` and the coherency inputs have no effect on it.
- R5: Suppose the sequencer is idle, the gating machine is normal, `core_wfi` is 1, and no interrupt or snoop is pending. Then the gating machine enters its gated state at the next edge, and `clk_en` goes to 0 one edge after that.
- R6: The gating machine never enters its gated state while the sequencer is outside idle. `clk_en` stays 1 during the whole power-down walk, even when `core_wfi` is 1.
- R7: While the clock is gated, any 1 bit in `irq` moves the machine to its awake state. `clk_en` returns to 1 two edges after the interrupt is first seen.
- R8: `snp_pend` forces `clk_en` to 1 in the same cycle, combinationally. It also ends gating, just as an interrupt does.
- R9: The awake state lasts at least one cycle. It returns to normal only once `core_wfi` is 0. Gating cannot start again until the core has left WFI.
- R10: While `wfi_gate_en` is 0, the WFI gate flag stays 0, so `clk_en` stays 1 even with the core in WFI.
- R11: The soft reset `soft_rst_n` takes effect after `RST_SYNC` cycles and clears both state machines and the WFI gate flag. If the sequencer was in power-off at that moment, a power-down gate flag is set. This flag holds `clk_en` at 0 until the synchronized soft reset is released.
- R12: The main reset `rst_n` clears all state asynchronously. `pwr_off_req` drops without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, ahead of the gate cell |
| rst_n | input | 1 | Main reset, asynchronous, active low |
| soft_rst_n | input | 1 | Soft reset from the system controller, active low |
| wfi_gate_en | input | 1 | Enables clock gating in WFI |
| flush_req | input | 1 | Core request to flush the cache and begin the power-down walk |
| flush_done | input | 1 | Cache flush complete |
| core_wfi | input | 1 | Core is halted in wait-for-interrupt |
| coh_req | input | 1 | Coherency connection request |
| coh_ack | input | 1 | Coherency connection acknowledge |
| snp_pend | input | 1 | A snoop flit is about to arrive |
| irq | input | N_IRQ | Interrupt sources; any 1 bit wakes the clock |
| clk_en | output | 1 | Enable for the cluster clock-gate cell |
| pwr_off_req | output | 1 | The cluster is idle and asks to be powered off |

## Verification
The hardest situation to reach is the power-down gate. It requires the sequencer to be in power-off and the soft reset to be applied. The clock enable must then fall only after the synchronizer has passed the soft reset through, and must rise again only after the release has been synchronized in the same way. The bench first drives the full power-down walk with directed values at each step. It holds each blocking condition for several cycles before releasing it. It then pulls the soft reset low and samples `clk_en` at the exact edge counts the synchronizer depth predicts.

The snoop bypass is checked in a separate situation. The bench raises the snoop in the middle of a gated cycle and samples before the next edge. It then confirms that `clk_en` stays low for one more cycle, because the registered gate flag still holds, before the clock returns.

// File: rtl/cpu_lp_pkg.sv
package cpu_lp_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE     = 3'd0,
    SEQ_FLUSH    = 3'd1,
    SEQ_WAIT_WFI = 3'd2,
    SEQ_EXIT_COH = 3'd3,
    SEQ_PWR_OFF  = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    WG_NORMAL = 2'd0,
    WG_GATED  = 2'd1,
    WG_AWAKE  = 2'd2
  } wfi_state_e;

endpackage

// File: rtl/lp_rst_sync.sv
module lp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst_n,
  output logic soft_ok
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= soft_rst_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], soft_rst_n};
      end
    end
  endgenerate

  assign soft_ok = sync_q[LAST];
endmodule

// File: rtl/lp_pwr_seq.sv
module lp_pwr_seq
  import cpu_lp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       flush_req,
  input  logic       flush_done,
  input  logic       core_wfi,
  input  logic       coh_req,
  input  logic       coh_ack,
  output seq_state_e state,
  output logic       idle,
  output logic       pwr_off
);
  seq_state_e state_q, state_d;
  logic       coh_gone;

  assign coh_gone = !coh_req && !coh_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:     if (flush_req)  state_d = SEQ_FLUSH;
      SEQ_FLUSH:    if (flush_done) state_d = SEQ_WAIT_WFI;
      SEQ_WAIT_WFI: if (core_wfi)   state_d = SEQ_EXIT_COH;
      SEQ_EXIT_COH: if (coh_gone)   state_d = SEQ_PWR_OFF;
      SEQ_PWR_OFF:                  state_d = SEQ_PWR_OFF;
      default:                      state_d = SEQ_IDLE;
    endcase
    if (clr) state_d = SEQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign state   = state_q;
  assign idle    = (state_q == SEQ_IDLE);
  assign pwr_off = (state_q == SEQ_PWR_OFF);
endmodule

// File: rtl/lp_wfi_gate.sv
module lp_wfi_gate
  import cpu_lp_pkg::*;
#(
  parameter int N_IRQ = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             seq_idle,
  input  logic             core_wfi,
  input  logic [N_IRQ-1:0] irq,
  input  logic             snp_pend,
  input  logic             gate_en,
  output wfi_state_e       state,
  output logic             gate_q
);
  wfi_state_e state_q, state_d;
  logic       wake;
  logic       gate_d;

  assign wake = (|irq) || snp_pend;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WG_NORMAL: if (seq_idle && core_wfi && !wake) state_d = WG_GATED;
      WG_GATED:  if (wake)                          state_d = WG_AWAKE;
      WG_AWAKE:  if (!core_wfi)                     state_d = WG_NORMAL;
      default:                                      state_d = WG_NORMAL;
    endcase
    if (clr) state_d = WG_NORMAL;
  end

  assign gate_d = gate_en && (state_q == WG_GATED) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WG_NORMAL;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gate_q  <= gate_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/cpu_lp_ctrl.sv
module cpu_lp_ctrl
  import cpu_lp_pkg::*;
#(
  parameter int N_IRQ    = 7,
  parameter int RST_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst_n,
  input  logic             wfi_gate_en,
  input  logic             flush_req,
  input  logic             flush_done,
  input  logic             core_wfi,
  input  logic             coh_req,
  input  logic             coh_ack,
  input  logic             snp_pend,
  input  logic [N_IRQ-1:0] irq,
  output logic             clk_en,
  output logic             pwr_off_req
);
  logic       soft_ok;
  logic       clr;
  seq_state_e seq_state;
  logic       seq_idle;
  logic       seq_off;
  wfi_state_e wfi_state;
  logic       wfi_gate_q;
  logic       pd_gate_q, pd_gate_d;

  lp_rst_sync #(.STAGES(RST_SYNC)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_n (soft_rst_n),
    .soft_ok    (soft_ok)
  );

  assign clr = !soft_ok;

  lp_pwr_seq i_pwr_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .flush_req  (flush_req),
    .flush_done (flush_done),
    .core_wfi   (core_wfi),
    .coh_req    (coh_req),
    .coh_ack    (coh_ack),
    .state      (seq_state),
    .idle       (seq_idle),
    .pwr_off    (seq_off)
  );

  lp_wfi_gate #(.N_IRQ(N_IRQ)) i_wfi_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .seq_idle (seq_idle),
    .core_wfi (core_wfi),
    .irq      (irq),
    .snp_pend (snp_pend),
    .gate_en  (wfi_gate_en),
    .state    (wfi_state),
    .gate_q   (wfi_gate_q)
  );

  // Power-down gate: captured when the soft reset lands in power-off,
  // held until the synchronized soft reset is released.
  assign pd_gate_d = clr && (seq_off || pd_gate_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_gate_q <= 1'b0;
    else        pd_gate_q <= pd_gate_d;
  end

  assign clk_en      = (!wfi_gate_q && !pd_gate_q) || snp_pend;
  assign pwr_off_req = seq_off;
endmodule

// File: rtl/cpu_lp_ctrl_chk.sv
module cpu_lp_ctrl_chk
  import cpu_lp_pkg::*;
#(
  parameter int N_IRQ = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_ok,
  input logic             wfi_gate_en,
  input logic             core_wfi,
  input logic             snp_pend,
  input logic [N_IRQ-1:0] irq,
  input logic             clk_en,
  input logic             pwr_off_req,
  input seq_state_e       seq_state,
  input wfi_state_e       wfi_state,
  input logic             wfi_gate_q,
  input logic             pd_gate_q
);

  a_r8_snoop_forces_en: assert property (@(posedge clk) disable iff (!rst_n)
    snp_pend |-> clk_en);

  a_r2_off_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_off_req && !$past(pwr_off_req)) |-> $past(seq_state == SEQ_EXIT_COH));

  a_r4_off_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_off_req && soft_ok) |=> pwr_off_req);

  a_r6_gate_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wfi_state == WG_GATED && $past(wfi_state != WG_GATED))
      |-> $past(seq_state == SEQ_IDLE && core_wfi));

  a_r7_wake_leaves_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (wfi_state == WG_GATED && ((|irq) || snp_pend) && soft_ok)
      |=> (wfi_state == WG_AWAKE));

  a_r10_cfg_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!wfi_gate_en) |-> !wfi_gate_q);

  a_r11_pd_only_soft: assert property (@(posedge clk) disable iff (!rst_n)
    pd_gate_q |-> $past(!soft_ok));

endmodule

bind cpu_lp_ctrl cpu_lp_ctrl_chk #(.N_IRQ(N_IRQ)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_ok     (soft_ok),
  .wfi_gate_en (wfi_gate_en),
  .core_wfi    (core_wfi),
  .snp_pend    (snp_pend),
  .irq         (irq),
  .clk_en      (clk_en),
  .pwr_off_req (pwr_off_req),
  .seq_state   (seq_state),
  .wfi_state   (wfi_state),
  .wfi_gate_q  (wfi_gate_q),
  .pd_gate_q   (pd_gate_q)
);

// File: tb/test_cpu_lp_ctrl.sv
`timescale 1ns/1ps
module test_cpu_lp_ctrl;
  localparam int CLK_P    = 10;
  localparam int N_IRQ    = 7;
  localparam int RST_SYNC = 2;

  logic             clk = 1'b0;
  logic             rst_n, soft_rst_n, wfi_gate_en;
  logic             flush_req, flush_done, core_wfi, coh_req, coh_ack, snp_pend;
  logic [N_IRQ-1:0] irq;
  logic             clk_en, pwr_off_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cpu_lp_ctrl #(.N_IRQ(N_IRQ), .RST_SYNC(RST_SYNC)) i_cpu_lp_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .wfi_gate_en(wfi_gate_en),
    .flush_req(flush_req), .flush_done(flush_done), .core_wfi(core_wfi),
    .coh_req(coh_req), .coh_ack(coh_ack), .snp_pend(snp_pend), .irq(irq),
    .clk_en(clk_en), .pwr_off_req(pwr_off_req)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; soft_rst_n = 1'b1; wfi_gate_en = 1'b1;
    flush_req = 0; flush_done = 0; core_wfi = 0; coh_req = 1; coh_ack = 1;
    snp_pend = 0; irq = '0;
    tick(2);
    rst_n = 1'b1;
    tick(RST_SYNC + 1);
  endtask

  task automatic run_to_off();
    flush_req = 1; tick(1); flush_req = 0;
    flush_done = 1; tick(1); flush_done = 0;
    core_wfi = 1; tick(1);
    coh_req = 0; coh_ack = 0; tick(1);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(clk_en, 1'b1, "R1 clk_en after reset");
    chk(pwr_off_req, 1'b0, "R1 pwr_off_req after reset");
  endtask

  task automatic t_sequence();
    do_reset();
    flush_req = 1; tick(1); flush_req = 0;
    tick(3);
    chk(pwr_off_req, 1'b0, "R2 waits for flush_done");
    flush_done = 1; tick(1); flush_done = 0;
    tick(3);
    chk(pwr_off_req, 1'b0, "R2 waits for core_wfi");
    core_wfi = 1; coh_req = 1; coh_ack = 0; tick(1);
    tick(3);
    chk(pwr_off_req, 1'b0, "R3 coh_req high holds");
    chk(clk_en, 1'b1, "R6 no gating while sequencing");
    coh_req = 0; coh_ack = 1; tick(3);
    chk(pwr_off_req, 1'b0, "R3 coh_ack high holds");
    coh_ack = 0; tick(1);
    chk(pwr_off_req, 1'b1, "R2 power-off request raised");
    chk(clk_en, 1'b1, "R6 no gating in power-off");
    flush_req = 1; core_wfi = 0; coh_req = 1; coh_ack = 1; tick(5);
    flush_req = 0;
    chk(pwr_off_req, 1'b1, "R4 power-off is sticky");
  endtask

  task automatic t_soft_reset();
    do_reset();
    run_to_off();
    chk(pwr_off_req, 1'b1, "R11 setup power-off");
    soft_rst_n = 0; tick(RST_SYNC);
    chk(clk_en, 1'b1, "R11 clk_en before sync completes");
    tick(1);
    chk(pwr_off_req, 1'b0, "R11 soft reset clears sequencer");
    chk(clk_en, 1'b0, "R11 power-down gate holds clock off");
    tick(4);
    chk(clk_en, 1'b0, "R11 gate held during soft reset");
    soft_rst_n = 1; tick(RST_SYNC);
    chk(clk_en, 1'b0, "R11 gate held until release synced");
    tick(1);
    chk(clk_en, 1'b1, "R11 gate cleared after release");
  endtask

  task automatic t_main_reset();
    do_reset();
    run_to_off();
    chk(pwr_off_req, 1'b1, "R12 setup power-off");
    #(CLK_P/4);
    rst_n = 0;
    #1;
    chk(pwr_off_req, 1'b0, "R12 async clear without edge");
    tick(1);
    rst_n = 1;
    tick(RST_SYNC + 1);
  endtask

  task automatic t_wfi_irq();
    do_reset();
    coh_req = 0; coh_ack = 0;
    core_wfi = 1; tick(1);
    chk(clk_en, 1'b1, "R5 one edge after wfi still enabled");
    tick(1);
    chk(clk_en, 1'b0, "R5 clock gated");
    irq = 7'b0001000; tick(1);
    chk(clk_en, 1'b0, "R7 gate flag lags one cycle");
    tick(1);
    chk(clk_en, 1'b1, "R7 interrupt wakes clock");
    irq = '0; tick(4);
    chk(clk_en, 1'b1, "R9 awake while core stays in wfi");
    core_wfi = 0; tick(1);
    core_wfi = 1; tick(2);
    chk(clk_en, 1'b0, "R9 gating again after leaving wfi");
    irq = 7'b1000000; tick(2); irq = '0; core_wfi = 0; tick(1);
  endtask

  task automatic t_snoop();
    do_reset();
    core_wfi = 1; tick(2);
    chk(clk_en, 1'b0, "R8 setup gated");
    snp_pend = 1; #1;
    chk(clk_en, 1'b1, "R8 snoop raises clk_en same cycle");
    tick(1);
    snp_pend = 0; #1;
    chk(clk_en, 1'b0, "R8 registered flag still set");
    tick(1);
    chk(clk_en, 1'b1, "R8 snoop ended gating");
    core_wfi = 0; tick(1);
  endtask

  task automatic t_cfg_off();
    do_reset();
    wfi_gate_en = 0; core_wfi = 1; tick(5);
    chk(clk_en, 1'b1, "R10 disabled gating keeps clock");
    wfi_gate_en = 1; tick(1);
    chk(clk_en, 1'b0, "R10 enabling gating stops clock");
    core_wfi = 0; irq = 7'b0000001; tick(2); irq = '0;
  endtask

  initial begin
    t_reset_state();
    t_sequence();
    t_soft_reset();
    t_main_reset();
    t_wfi_irq();
    t_snoop();
    t_cfg_off();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule